// File: doc/BRIEF.md
# Write Strobe Legality Monitor

A passive observer placed on the write address and write data channels of an AXI4 port with a 32-bit data path. It never drives a handshake signal. It takes each accepted write address, keeps its start offset, transfer size, beat count and burst type, and then pairs that address with the write data beats that follow. For every beat it works out the byte lanes that beat is allowed to use, and it reports any asserted strobe that falls outside them.

Only the first beat of an incrementing burst can be unaligned. On that beat the lanes below the start offset are forbidden. Every later beat may use the whole size-wide container at the next incremented aligned address, with the lane number wrapping modulo the bus width. Any subset of the permitted lanes is legal, including no lanes at all. The monitor also counts beats against the length field to catch a misplaced or missing last flag. It rejects fixed and wrapping bursts, and sizes wider than the bus, as unsupported. Data beats that arrive before their address wait in a four-entry queue. Addresses that arrive before their data wait in a four-entry queue too.

Violations appear as a registered one-cycle pulse, together with a flag vector and the index of the beat that caused them.

Top module: `wstrb_legality_mon`

## Requirements
- R1: After reset err_o, err_flags_o and err_beat_o are all zero, and no burst or beat is pending.
- R2: On beat 0 of an incrementing burst, a strobe bit set on a lane below the start offset (address bits [1:0]) sets err_flags_o[0] (strobe violation), with err_beat_o = 0. For 4-byte size at offset 1, strobe bit 0 is the only forbidden bit.
- R3: Any subset of the permitted lanes raises no error, and an all-zero strobe on beat 0 is legal.
- R4: Beat n>0 may use the S-byte container at lane ((offset aligned down to S) + n*S) mod 4, where size code 0/1/2 means S = 1/2/4 bytes. A strobe outside that container sets err_flags_o[0], with err_beat_o = n.
- R5: A last flag on any beat other than beat number len, or a missing last flag on beat len, sets err_flags_o[1] (last violation), with err_beat_o equal to that beat's index.
- R6: A burst spans exactly len+1 beats. The next queued address then takes over, and its offset applies to its own first beat.
- R7: A burst type other than INCR (2'b01), or a size code above 2, sets err_flags_o[2] (unsupported) once when its address is taken up, with err_beat_o = 0. Its beats get only the last-flag check and no strobe check.
- R8: Up to 4 data beats that come before their address are held and checked once the address arrives. A data beat or address accepted while its queue is full is dropped and sets err_flags_o[3] (overflow).
- R9: An address or data beat counts only in a cycle where both valid and ready are high.
- R10: err_o is a registered pulse, high for exactly one cycle per offending event, and equal to the OR of err_flags_o (bit 0 strobe, bit 1 last, bit 2 unsupported, bit 3 overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_i | input | 1 | Write address ready |
| aw_addr_i | input | ADDR_W | Write start address |
| aw_len_i | input | LEN_W | Beat count minus one |
| aw_size_i | input | 3 | Log2 of bytes per beat |
| aw_burst_i | input | 2 | Burst type (01 = INCR) |
| w_valid_i | input | 1 | Write data valid |
| w_ready_i | input | 1 | Write data ready |
| w_strb_i | input | DATA_W/8 | Byte lane strobes |
| w_last_i | input | 1 | Final beat flag |
| err_o | output | 1 | One-cycle violation pulse |
| err_flags_o | output | 4 | Violation kinds for the pulse |
| err_beat_o | output | LEN_W | Beat index of the violation |

## Verification
The bench targets unaligned first beats at offsets 1 and 3. A monitor that ignores the start offset would pass lane 0 at offset 1. A monitor that applies the offset to every beat would reject the full-width later beats. Narrow 1- and 2-byte bursts check that the container advances and wraps to lane 0; a design with a fixed container would flag legal beats. Other cases cover last flags one beat early and missing, data ahead of its address, a fifth early beat, and back-to-back bursts with different offsets. Any error in beat counting or queue handling shows up as spurious or missing pulses on a later beat. Valid held high without ready must leave the following burst clean, and would not if a stray beat were taken in.

// File: rtl/wstrb_mon_pkg.sv
package wstrb_mon_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned FL_STRB  = 0;
  localparam int unsigned FL_LAST  = 1;
  localparam int unsigned FL_UNSUP = 2;
  localparam int unsigned FL_OVFL  = 3;
endpackage

// File: rtl/wstrb_mon_fifo.sv
module wstrb_mon_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             ovfl_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic full, do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign ovfl_o  = push_i && !do_push;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8: occupancy never passes depth
  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R8: a dropped entry leaves occupancy unchanged
  assert_ovfl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovfl_o && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wstrb_mon_lane_mask.sv
module wstrb_mon_lane_mask #(
  parameter int unsigned LANES = 4,
  parameter int unsigned OFF_W = 2
) (
  input  logic [OFF_W-1:0] start_off_i,
  input  logic [OFF_W-1:0] lane_i,
  input  logic [2:0]       size_i,
  input  logic             first_i,
  output logic [LANES-1:0] mask_o
);
  int unsigned span;
  assign span = 32'd1 << size_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g] = (g >= int'(lane_i)) && (g < int'(lane_i) + int'(span))
                    && (!first_i || g >= int'(start_off_i));
  end

  // R3: the lane at the current container base is open on non-first beats
  always_comb begin
    if (!first_i && size_i <= 3'(OFF_W))
      assert_base_open_R3: assert (mask_o[lane_i]);
  end
endmodule

// File: rtl/wstrb_legality_mon.sv
module wstrb_legality_mon
  import wstrb_mon_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned LANES     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_valid_i,
  input  logic              aw_ready_i,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic [LEN_W-1:0]  aw_len_i,
  input  logic [2:0]        aw_size_i,
  input  logic [1:0]        aw_burst_i,
  input  logic              w_valid_i,
  input  logic              w_ready_i,
  input  logic [LANES-1:0]  w_strb_i,
  input  logic              w_last_i,
  output logic              err_o,
  output logic [FLAG_W-1:0] err_flags_o,
  output logic [LEN_W-1:0]  err_beat_o
);
  localparam int unsigned OFF_W = $clog2(LANES);
  localparam int unsigned AWE_W = OFF_W + 3 + LEN_W + 2;
  localparam int unsigned WE_W  = LANES + 1;

  logic unused_addr;
  assign unused_addr = ^aw_addr_i[ADDR_W-1:OFF_W];

  // address and data queues
  logic [AWE_W-1:0] aw_head;
  logic [WE_W-1:0]  w_head;
  logic aw_empty, w_empty, aw_ovfl, w_ovfl, ld, consume;

  wstrb_mon_fifo #(.WIDTH(AWE_W), .DEPTH(FIFO_DEPTH)) u_aw_q (
    .clk_i, .rst_ni,
    .push_i (aw_valid_i && aw_ready_i),
    .data_i ({aw_addr_i[OFF_W-1:0], aw_size_i, aw_len_i, aw_burst_i}),
    .pop_i  (ld),
    .data_o (aw_head),
    .empty_o(aw_empty),
    .ovfl_o (aw_ovfl)
  );

  wstrb_mon_fifo #(.WIDTH(WE_W), .DEPTH(FIFO_DEPTH)) u_w_q (
    .clk_i, .rst_ni,
    .push_i (w_valid_i && w_ready_i),
    .data_i ({w_strb_i, w_last_i}),
    .pop_i  (consume),
    .data_o (w_head),
    .empty_o(w_empty),
    .ovfl_o (w_ovfl)
  );

  logic [OFF_W-1:0] hd_off;
  logic [2:0]       hd_size;
  logic [LEN_W-1:0] hd_len;
  logic [1:0]       hd_burst;
  assign {hd_off, hd_size, hd_len, hd_burst} = aw_head;

  logic [LANES-1:0] bt_strb;
  logic             bt_last;
  assign {bt_strb, bt_last} = w_head;

  // burst context
  logic             active_q, incr_q;
  logic [OFF_W-1:0] off_q, lane_q;
  logic [2:0]       size_q;
  logic [LEN_W-1:0] beat_q, len_q;

  logic             incr_d;
  logic [OFF_W-1:0] ld_lane, step;

  assign ld      = !active_q && !aw_empty;
  assign consume = active_q && !w_empty;
  assign incr_d  = (hd_size <= 3'(OFF_W)) && (hd_burst == BURST_INCR);
  assign ld_lane = hd_off & ~OFF_W'((32'd1 << hd_size) - 32'd1);
  assign step    = OFF_W'(32'd1 << size_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      incr_q   <= 1'b0;
      off_q    <= '0;
      lane_q   <= '0;
      size_q   <= '0;
      beat_q   <= '0;
      len_q    <= '0;
    end else if (ld) begin
      active_q <= 1'b1;
      incr_q   <= incr_d;
      off_q    <= hd_off;
      lane_q   <= incr_d ? ld_lane : '0;
      size_q   <= hd_size;
      beat_q   <= '0;
      len_q    <= hd_len;
    end else if (consume) begin
      beat_q <= beat_q + 1'b1;
      lane_q <= lane_q + step;
      if (beat_q == len_q) active_q <= 1'b0;
    end
  end

  logic [LANES-1:0] mask;
  wstrb_mon_lane_mask #(.LANES(LANES), .OFF_W(OFF_W)) u_mask (
    .start_off_i(off_q),
    .lane_i     (lane_q),
    .size_i     (size_q),
    .first_i    (beat_q == '0),
    .mask_o     (mask)
  );

  // violation detection
  logic [FLAG_W-1:0] flags_d;
  logic [LEN_W-1:0]  beat_d;

  always_comb begin
    flags_d = '0;
    beat_d  = '0;
    if (ld && !incr_d) flags_d[FL_UNSUP] = 1'b1;
    if (consume) begin
      beat_d = beat_q;
      if (incr_q && |(bt_strb & ~mask)) flags_d[FL_STRB] = 1'b1;
      if (bt_last != (beat_q == len_q)) flags_d[FL_LAST] = 1'b1;
    end
    if (aw_ovfl || w_ovfl) flags_d[FL_OVFL] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      err_flags_o <= '0;
      err_beat_o  <= '0;
    end else begin
      err_o       <= |flags_d;
      err_flags_o <= flags_d;
      err_beat_o  <= beat_d;
    end
  end

  // R2: lane 0 on an offset first beat is always flagged
  assert_first_lane0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume && incr_q && beat_q == '0 && off_q != '0 && bt_strb[0]) |=> err_flags_o[FL_STRB]);

  // R5: early last flagged at the beat that carried it
  assert_early_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume && bt_last && beat_q != len_q) |=> (err_flags_o[FL_LAST] && err_beat_o == $past(beat_q)));

  // R6: beat counter stays within the burst length
  assert_beat_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> beat_q <= len_q);

  // R7: unsupported only reported on address take-up
  assert_unsup_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flags_o[FL_UNSUP] |-> ($past(ld) && err_beat_o == '0));

  // R10: a pulse needs a cause in the previous cycle
  assert_err_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(ld || consume || aw_ovfl || w_ovfl));
endmodule

// File: tb/sim_wstrb_legality_mon.sv
`timescale 1ns/1ps
module sim_wstrb_legality_mon;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        aw_valid, aw_ready, w_valid, w_ready, w_last;
  logic [31:0] aw_addr;
  logic [7:0]  aw_len;
  logic [2:0]  aw_size;
  logic [1:0]  aw_burst;
  logic [3:0]  w_strb;
  logic        err;
  logic [3:0]  err_flags;
  logic [7:0]  err_beat;

  always #2.5 clk = ~clk;

  wstrb_legality_mon u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_valid_i(aw_valid), .aw_ready_i(aw_ready), .aw_addr_i(aw_addr),
    .aw_len_i(aw_len), .aw_size_i(aw_size), .aw_burst_i(aw_burst),
    .w_valid_i(w_valid), .w_ready_i(w_ready), .w_strb_i(w_strb), .w_last_i(w_last),
    .err_o(err), .err_flags_o(err_flags), .err_beat_o(err_beat)
  );

  int n_chk = 0, n_fail = 0;
  int c_err, c_strb, c_last, c_unsup, c_ovfl, l_beat;
  bit done = 0;

  always @(negedge clk) if (rst_n && err) begin
    c_err++;
    if (err_flags[0]) c_strb++;
    if (err_flags[1]) c_last++;
    if (err_flags[2]) c_unsup++;
    if (err_flags[3]) c_ovfl++;
    l_beat = err_beat;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    c_err = 0; c_strb = 0; c_last = 0; c_unsup = 0; c_ovfl = 0; l_beat = -1;
  endtask

  task automatic aw(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                    input logic [1:0] b);
    @(negedge clk);
    aw_valid = 1; aw_ready = 1; aw_addr = a; aw_len = l; aw_size = s; aw_burst = b;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
  endtask

  task automatic wb(input logic [3:0] s, input logic l);
    @(negedge clk);
    w_valid = 1; w_ready = 1; w_strb = s; w_last = l;
    @(negedge clk);
    w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 err_o", err, 0);
    chk("R1 flags", err_flags, 0);
    chk("R1 beat", err_beat, 0);
  endtask

  task automatic t_first_beat();
    clr(); aw(32'h1, 3, 2, 2'b01);
    wb(4'b1110, 0); wb(4'hF, 0); wb(4'hF, 0); wb(4'b0001, 1); settle();
    chk("R3 legal unaligned burst", c_err, 0);
    clr(); aw(32'h1, 1, 2, 2'b01);
    wb(4'b0000, 0); wb(4'b0101, 1); settle();
    chk("R3 zero first strobe", c_err, 0);
    clr(); aw(32'h1, 0, 2, 2'b01); wb(4'b0011, 1); settle();
    chk("R2 lane0 at offset1", c_strb, 1);
    chk("R2 beat index", l_beat, 0);
    chk("R10 single pulse", c_err, 1);
    chk("R10 err_o low after", err, 0);
    clr(); aw(32'h3, 0, 2, 2'b01); wb(4'b0100, 1); settle();
    chk("R2 lane2 at offset3", c_strb, 1);
  endtask

  task automatic t_narrow();
    clr(); aw(32'h1, 2, 1, 2'b01);
    wb(4'b0010, 0); wb(4'b1100, 0); wb(4'b0011, 1); settle();
    chk("R4 halfword wrap legal", c_err, 0);
    clr(); aw(32'h1, 2, 1, 2'b01);
    wb(4'b0010, 0); wb(4'b0001, 0); wb(4'b0011, 1); settle();
    chk("R4 halfword wrong container", c_strb, 1);
    chk("R4 beat index", l_beat, 1);
    clr(); aw(32'h3, 1, 0, 2'b01); wb(4'b1000, 0); wb(4'b0001, 1); settle();
    chk("R4 byte wrap legal", c_err, 0);
    clr(); aw(32'h3, 1, 0, 2'b01); wb(4'b1000, 0); wb(4'b0010, 1); settle();
    chk("R4 byte wrong lane", c_strb, 1);
  endtask

  task automatic t_last();
    clr(); aw(32'h0, 3, 2, 2'b01);
    wb(4'hF, 0); wb(4'hF, 1); wb(4'hF, 0); wb(4'hF, 1); settle();
    chk("R5 early last", c_last, 1);
    chk("R5 early last beat", l_beat, 1);
    clr(); aw(32'h0, 1, 2, 2'b01); wb(4'hF, 0); wb(4'hF, 0); settle();
    chk("R5 missing last", c_last, 1);
    chk("R5 missing last beat", l_beat, 1);
  endtask

  task automatic t_b2b();
    clr(); aw(32'h0, 1, 2, 2'b01); aw(32'h2, 0, 2, 2'b01);
    wb(4'hF, 0); wb(4'hF, 1); wb(4'b0100, 1); settle();
    chk("R6 back to back legal", c_err, 0);
    clr(); aw(32'h0, 1, 2, 2'b01); aw(32'h2, 0, 2, 2'b01);
    wb(4'hF, 0); wb(4'hF, 1); wb(4'b0011, 1); settle();
    chk("R6 second offset applied", c_strb, 1);
    chk("R6 second beat index", l_beat, 0);
    chk("R6 no last error", c_last, 0);
    clr(); aw(32'h0, 15, 2, 2'b01);
    for (int i = 0; i < 16; i++) wb(4'hF, i == 15);
    settle();
    chk("R6 sixteen beats", c_err, 0);
  endtask

  task automatic t_unsup();
    clr(); aw(32'h1, 1, 2, 2'b10); wb(4'hF, 0); wb(4'h1, 1); settle();
    chk("R7 wrap unsupported", c_unsup, 1);
    chk("R7 no strobe check", c_strb, 0);
    chk("R7 beat index", l_beat, 0);
    clr(); aw(32'h0, 0, 2, 2'b00); wb(4'hF, 1); settle();
    chk("R7 fixed unsupported", c_unsup, 1);
    clr(); aw(32'h0, 0, 3, 2'b01); wb(4'hF, 1); settle();
    chk("R7 oversize", c_unsup, 1);
    chk("R7 total", c_err, 1);
  endtask

  task automatic t_early();
    clr(); wb(4'b1110, 0); wb(4'hF, 1); repeat (3) @(negedge clk);
    aw(32'h1, 1, 2, 2'b01); settle();
    chk("R8 early legal", c_err, 0);
    clr(); wb(4'b0001, 1); repeat (3) @(negedge clk);
    aw(32'h1, 0, 2, 2'b01); settle();
    chk("R8 early checked", c_strb, 1);
    clr();
    wb(4'hF, 0); wb(4'hF, 0); wb(4'hF, 0); wb(4'hF, 1); wb(4'hF, 0);
    aw(32'h0, 3, 2, 2'b01); settle();
    chk("R8 overflow", c_ovfl, 1);
    chk("R8 kept beats clean", c_err, 1);
  endtask

  task automatic t_handshake();
    clr();
    @(negedge clk);
    w_valid = 1; w_ready = 0; w_strb = 4'b0001; w_last = 1;
    aw_valid = 1; aw_ready = 0; aw_addr = 32'h1; aw_len = 0; aw_size = 2; aw_burst = 2'b01;
    repeat (3) @(negedge clk);
    w_valid = 0; aw_valid = 0; w_last = 0;
    settle();
    chk("R9 no handshake no error", c_err, 0);
    aw(32'h0, 0, 2, 2'b01); wb(4'hF, 1); settle();
    chk("R9 following burst clean", c_err, 0);
  endtask

  initial begin
    rst_n = 0; aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
    aw_addr = '0; aw_len = '0; aw_size = '0; aw_burst = '0; w_strb = '0;
    clr();
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_first_beat();
    t_narrow();
    t_last();
    t_b2b();
    t_unsup();
    t_early();
    t_handshake();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule